// File: doc/BRIEF.md
# Peripheral Interrupt Flag Aggregator

This block gathers interrupt events from the motor-control peripherals of a chip and merges them onto one active-low interrupt line to a processor core. The sources are a PWM period synchronisation pulse, a PWM fault (trip) pulse, and level changes on a bank of general-purpose I/O pins. Each event sets a sticky flag. The flags sit in three read-to-clear registers: one for the two PWM sources and two for the pin bank, which is split into a low group and a high group.

Software learns what happened by reading the flag registers. The read strobe clears the register it addresses. The interrupt line stays low while any flag in any register is pending, so the core should treat it as level-sensitive. A small state machine drives the line. It has two states, `LINE_IDLE` (line high) and `LINE_ASSERTED` (line low). The transition `RAISE` goes from idle to asserted when some flag is pending. The transition `RELEASE` goes from asserted back to idle when no flag is pending. Enable bits gate the PWM sources. A per-pin mask gates the pin events.

Top module: `pirq_aggregator`

## Requirements
- R1: With sync enabled (control register, address 3, bit 0), a sync pulse sampled at a clock edge sets bit 0 of the core flag register (address 0) at that edge.
- R2: With trip enabled (address 3, bit 1), a trip pulse sampled at a clock edge sets bit 1 of address 0 at that edge.
- R3: A sync or trip pulse whose enable bit is 0 sets no flag and leaves the interrupt line high.
- R4: Each pin passes through a two-flop synchroniser. A change of its synchronised level, rising or falling, sets its flag two edges after the first edge that samples the new level, but only if its mask bit is 1 at that edge. Pins 0..7 map to bits 0..7 of address 1. Pins 8..11 map to bits 0..3 of address 2. Mask bits for pins 0..7 are in address 4 and mask bits for pins 8..11 are in address 5.
- R5: `irq_n` is low in the cycle after any flag was pending at a clock edge, and high in the cycle after no flag was pending.
- R6: A read strobe on address 0 returns the current flags in the same cycle and clears both bits at the next edge.
- R7: A read strobe on address 1 or 2 returns that register and clears every bit of that register only. The other pin group is untouched.
- R8: An event that sets a flag at the same edge as a clearing read of that register leaves the flag set. The read returns the value from before the event.
- R9: Reset clears all flags, enables and masks, and drives `irq_n` high.
- R10: Writes to addresses 0, 1 and 2 have no effect. Addresses 3, 4 and 5 read back what was written to them, in their low 2, 8 and 4 bits respectively. Addresses 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_evt_i | input | 1 | PWM synchronisation pulse, synchronous to clk |
| trip_evt_i | input | 1 | PWM trip pulse, synchronous to clk |
| pin_i | input | 12 | Asynchronous general-purpose pin levels |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears the addressed flag register) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| irq_n | output | 1 | Active-low level interrupt to the core |

## Verification
A flag that is stuck set shows at the ports as `irq_n` staying low after every clearing read. A flag that is lost shows as `irq_n` staying high one cycle after the event should have been captured. Either fault also appears on `bus_rdata` at the next read of that register. A line state machine that sits in the wrong state shows a mismatch on `irq_n` within one clock. Because of this, the reference model compares `irq_n` on every cycle and compares `bus_rdata` on every read strobe, including reads that land in the same cycle as a new event.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    typedef enum logic {
        LINE_IDLE     = 1'b0,
        LINE_ASSERTED = 1'b1
    } line_state_t;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CORE_FLAGS = 3'd0;
    localparam logic [ADDR_W-1:0] A_PIN_LO     = 3'd1;
    localparam logic [ADDR_W-1:0] A_PIN_HI     = 3'd2;
    localparam logic [ADDR_W-1:0] A_CONTROL    = 3'd3;
    localparam logic [ADDR_W-1:0] A_MASK_LO    = 3'd4;
    localparam logic [ADDR_W-1:0] A_MASK_HI    = 3'd5;

    localparam int SYNC_BIT = 0;
    localparam int TRIP_BIT = 1;

endpackage

// File: rtl/pirq_pin_detect.sv
module pirq_pin_detect #(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] evt_o
);

    for (genvar g = 0; g < N; g++) begin : g_pin
        logic meta_q, sync_q, prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= pin_i[g];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign evt_o[g] = (sync_q ^ prev_q) & mask_i[g];
    end

endmodule

// File: rtl/pirq_flag_group.sv
module pirq_flag_group #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] flags_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_o <= '0;
        end else begin
            flags_o <= (clr_i ? '0 : flags_o) | set_i;
        end
    end

    // R8
    keep_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i)));

    // R7
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (set_i == '0)) |=> (flags_o == '0));

endmodule

// File: rtl/pirq_line_fsm.sv
module pirq_line_fsm
    import pirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    output logic irq_n_o
);

    line_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_IDLE:     if (pending_i)  state_d = LINE_ASSERTED; // RAISE
            LINE_ASSERTED: if (!pending_i) state_d = LINE_IDLE;     // RELEASE
            default:                       state_d = LINE_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            LINE_ASSERTED: irq_n_o = 1'b0;
            default:       irq_n_o = 1'b1;
        endcase
    end

    // R5
    raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending_i |=> !irq_n_o);

    // R5
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pending_i |=> irq_n_o);

endmodule

// File: rtl/pirq_aggregator.sv
module pirq_aggregator
    import pirq_pkg::*;
#(
    parameter int NUM_PIN = 12,
    parameter int GRP_LO_W = 8,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sync_evt_i,
    input  logic                trip_evt_i,
    input  logic [NUM_PIN-1:0]  pin_i,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                irq_n
);

    localparam int GRP_HI_W = NUM_PIN - GRP_LO_W;

    logic [1:0]          en_q;
    logic [GRP_LO_W-1:0] mask_lo_q;
    logic [GRP_HI_W-1:0] mask_hi_q;
    logic [1:0]          core_set, core_flags;
    logic [NUM_PIN-1:0]  pin_evt;
    logic [GRP_LO_W-1:0] lo_flags;
    logic [GRP_HI_W-1:0] hi_flags;
    logic                clr_core, clr_lo, clr_hi, pending;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= '0;
            mask_lo_q <= '0;
            mask_hi_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_CONTROL) en_q      <= bus_wdata[1:0];
            if (bus_addr == A_MASK_LO) mask_lo_q <= bus_wdata[GRP_LO_W-1:0];
            if (bus_addr == A_MASK_HI) mask_hi_q <= bus_wdata[GRP_HI_W-1:0];
        end
    end

    assign core_set[SYNC_BIT] = sync_evt_i & en_q[SYNC_BIT];
    assign core_set[TRIP_BIT] = trip_evt_i & en_q[TRIP_BIT];

    assign clr_core = bus_rd && (bus_addr == A_CORE_FLAGS);
    assign clr_lo   = bus_rd && (bus_addr == A_PIN_LO);
    assign clr_hi   = bus_rd && (bus_addr == A_PIN_HI);

    pirq_pin_detect #(.N(NUM_PIN)) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .mask_i ({mask_hi_q, mask_lo_q}),
        .evt_o  (pin_evt)
    );

    pirq_flag_group #(.W(2)) u_core (
        .clk (clk), .rst_n (rst_n), .set_i (core_set),
        .clr_i (clr_core), .flags_o (core_flags)
    );

    pirq_flag_group #(.W(GRP_LO_W)) u_lo (
        .clk (clk), .rst_n (rst_n), .set_i (pin_evt[GRP_LO_W-1:0]),
        .clr_i (clr_lo), .flags_o (lo_flags)
    );

    pirq_flag_group #(.W(GRP_HI_W)) u_hi (
        .clk (clk), .rst_n (rst_n), .set_i (pin_evt[NUM_PIN-1:GRP_LO_W]),
        .clr_i (clr_hi), .flags_o (hi_flags)
    );

    assign pending = (|core_flags) | (|lo_flags) | (|hi_flags);

    pirq_line_fsm u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (pending),
        .irq_n_o   (irq_n)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CORE_FLAGS: bus_rdata[1:0]          = core_flags;
            A_PIN_LO:     bus_rdata[GRP_LO_W-1:0] = lo_flags;
            A_PIN_HI:     bus_rdata[GRP_HI_W-1:0] = hi_flags;
            A_CONTROL:    bus_rdata[1:0]          = en_q;
            A_MASK_LO:    bus_rdata[GRP_LO_W-1:0] = mask_lo_q;
            A_MASK_HI:    bus_rdata[GRP_HI_W-1:0] = mask_hi_q;
            default:      bus_rdata               = '0;
        endcase
    end

    // R3
    sync_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q[SYNC_BIT] && !core_flags[SYNC_BIT]) |=> !core_flags[SYNC_BIT]);

    // R3
    trip_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q[TRIP_BIT] && !core_flags[TRIP_BIT]) |=> !core_flags[TRIP_BIT]);

endmodule

// File: tb/tb_pirq_aggregator.sv
module tb_pirq_aggregator;

    localparam int NP = 12;
    localparam int GA = 8;
    localparam int GB = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sync_evt_i = 1'b0, trip_evt_i = 1'b0;
    logic [NP-1:0] pin_i = '0;
    logic [2:0]    bus_addr = '0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0]   bus_wdata = '0;
    logic [15:0]   bus_rdata;
    logic          irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pirq_aggregator dut (
        .clk(clk), .rst_n(rst_n), .sync_evt_i(sync_evt_i), .trip_evt_i(trip_evt_i),
        .pin_i(pin_i), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    // behavioural reference state
    logic [1:0]    m_cf, m_en;
    logic [GA-1:0] m_pa, m_mlo;
    logic [GB-1:0] m_pb, m_mhi;
    logic          m_irq_n;
    logic [NP-1:0] h1, h2, h3;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mread(input logic [2:0] a);
        case (a)
            3'd0:    return {14'd0, m_cf};
            3'd1:    return {8'd0, m_pa};
            3'd2:    return {12'd0, m_pb};
            3'd3:    return {14'd0, m_en};
            3'd4:    return {8'd0, m_mlo};
            3'd5:    return {12'd0, m_mhi};
            default: return 16'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic          any;
        logic [NP-1:0] ev;
        if (!rst_n) begin
            m_cf = '0; m_en = '0; m_pa = '0; m_pb = '0; m_mlo = '0; m_mhi = '0;
            m_irq_n = 1'b1; h1 = '0; h2 = '0; h3 = '0;
        end else begin
            any = (|m_cf) | (|m_pa) | (|m_pb);
            ev  = (h2 ^ h3) & {m_mhi, m_mlo};
            m_cf = ((bus_rd && bus_addr == 3'd0) ? 2'b00 : m_cf)
                   | {trip_evt_i & m_en[1], sync_evt_i & m_en[0]};
            m_pa = ((bus_rd && bus_addr == 3'd1) ? '0 : m_pa) | ev[GA-1:0];
            m_pb = ((bus_rd && bus_addr == 3'd2) ? '0 : m_pb) | ev[NP-1:GA];
            if (bus_wr) begin
                if (bus_addr == 3'd3) m_en  = bus_wdata[1:0];
                if (bus_addr == 3'd4) m_mlo = bus_wdata[GA-1:0];
                if (bus_addr == 3'd5) m_mhi = bus_wdata[GB-1:0];
            end
            m_irq_n = !any;
            h3 = h2; h2 = h1; h1 = pin_i;
        end
    end

    // R5 / R9: interrupt line compared against the model every cycle
    always @(negedge clk) begin
        if (!done && rst_n) chk(irq_n === m_irq_n, "R5 R9 irq_n", irq_n, m_irq_n);
    end

    // one clock: drive at negedge, check read data, wait for the edge
    task automatic cyc(input logic s, input logic t, input logic wr, input logic rd,
                       input logic [2:0] a, input logic [15:0] wd, input int exp, input string tag);
        @(negedge clk);
        sync_evt_i = s; trip_evt_i = t; bus_wr = wr; bus_rd = rd;
        bus_addr = a; bus_wdata = wd;
        #1;
        if (rd) begin
            chk(bus_rdata === mread(a), tag, bus_rdata, mread(a));
            if (exp >= 0) chk(bus_rdata === exp[15:0], tag, bus_rdata, exp);
        end
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 3'd0, 16'd0, -1, "");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        chk(irq_n === 1'b1, "R9 irq_n after reset", irq_n, 1);
        for (int a = 0; a < 8; a++) cyc(0, 0, 0, 1, 3'(a), 16'd0, 0, "R9 reset value");

        // R3: disabled sources
        cyc(1, 1, 0, 0, 3'd0, 16'd0, -1, "");
        idle(2);
        #1 chk(irq_n === 1'b1, "R3 line stays high", irq_n, 1);
        cyc(0, 0, 0, 1, 3'd0, 16'd0, 0, "R3 no flag");

        // R1 / R6
        cyc(0, 0, 1, 0, 3'd3, 16'h0003, -1, "");
        cyc(1, 0, 0, 0, 3'd0, 16'd0, -1, "");
        idle(2);
        #1 chk(irq_n === 1'b0, "R1 line low", irq_n, 0);
        cyc(0, 0, 0, 1, 3'd0, 16'd0, 1, "R1 R6 sync flag read");
        cyc(0, 0, 0, 1, 3'd0, 16'd0, 0, "R6 cleared");
        idle(1);
        #1 chk(irq_n === 1'b1, "R6 line released", irq_n, 1);

        // R2
        cyc(0, 1, 0, 0, 3'd0, 16'd0, -1, "");
        cyc(0, 0, 0, 1, 3'd0, 16'd0, 2, "R2 trip flag read");

        // R8: event during clearing read
        cyc(1, 0, 0, 0, 3'd0, 16'd0, -1, "");
        cyc(0, 1, 0, 1, 3'd0, 16'd0, 1, "R8 read returns old value");
        cyc(0, 0, 0, 1, 3'd0, 16'd0, 2, "R8 new flag kept");

        // R10
        cyc(0, 0, 1, 0, 3'd4, 16'h000F, -1, "");
        cyc(0, 0, 1, 0, 3'd5, 16'h000F, -1, "");
        cyc(0, 0, 1, 0, 3'd0, 16'hFFFF, -1, "");
        cyc(0, 0, 1, 0, 3'd1, 16'hFFFF, -1, "");
        cyc(0, 0, 1, 0, 3'd2, 16'hFFFF, -1, "");
        cyc(0, 0, 0, 1, 3'd0, 16'd0, 0, "R10 write to flags ignored");
        cyc(0, 0, 0, 1, 3'd1, 16'd0, 0, "R10 write to flags ignored");
        cyc(0, 0, 0, 1, 3'd3, 16'd0, 3, "R10 control readback");
        cyc(0, 0, 0, 1, 3'd4, 16'd0, 15, "R10 mask readback");
        cyc(0, 0, 0, 1, 3'd6, 16'd0, 0, "R10 spare address");

        // R4 / R7: pins 2, 9 enabled, 6 masked out
        @(negedge clk); pin_i = 12'h244;
        idle(5);
        cyc(0, 0, 0, 1, 3'd1, 16'd0, 4, "R4 low group flag");
        cyc(0, 0, 0, 1, 3'd2, 16'd0, 2, "R4 R7 high group untouched");
        cyc(0, 0, 0, 1, 3'd1, 16'd0, 0, "R7 low group cleared");
        cyc(0, 0, 0, 1, 3'd2, 16'd0, 0, "R7 high group cleared");
        @(negedge clk); pin_i = 12'h000;
        idle(5);
        cyc(0, 0, 0, 1, 3'd1, 16'd0, 4, "R4 falling edge");
        cyc(0, 0, 0, 1, 3'd2, 16'd0, 2, "R4 falling edge high");

        // R8 on pins: clearing read at several offsets after a change
        for (int d = 0; d < 5; d++) begin
            @(negedge clk); pin_i[3] = ~pin_i[3];
            idle(d);
            cyc(0, 0, 0, 1, 3'd1, 16'd0, -1, "R8 R7 pin read");
            idle(4);
            cyc(0, 0, 0, 1, 3'd1, 16'd0, -1, "R8 R7 pin read");
        end

        // mixed stimulus against the model
        for (int i = 0; i < 400; i++) begin
            logic [2:0] a;
            a = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 3) == 0) begin
                @(negedge clk); pin_i = NP'($urandom);
            end
            cyc(1'($urandom), 1'($urandom), ($urandom_range(0, 9) == 0) && a >= 3,
                $urandom_range(0, 2) == 0, a, 16'($urandom), -1, "R1 R2 R4 R6 R7 model");
        end
        idle(3);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule